// File: doc/BRIEF.md
# Sequential Booth Signed Multiplier

This block multiplies a signed multiplicand of XW bits by a signed multiplier of YW bits, both in two's complement, and returns the signed product of XW+YW bits. It retires one multiplier bit per clock. Each step looks at a pair of adjacent multiplier bits, may add or subtract the multiplicand in the top of a working register, and then shifts that register right by one place with the sign bit copied.

A caller presents both operands with a one-cycle start request while the block is idle. Busy rises on the following cycle. After YW steps the block raises done for one cycle, and the product stays on its output until the next accepted start. The positive and negative images of the multiplicand are built once, when the operands are taken. A guard bit above the multiplicand field means the most negative multiplicand gives the right answer without any special handling.

Top module: `booth_seq_mult`

## Requirements
- R1: While reset is high, and on the first idle cycle after it, busy and done are 0 and product is 0.
- R2: For every pair of operands, product read as a signed XW+YW-bit value equals the signed multiplicand times the signed multiplier.
- R3: A multiplicand equal to -2^(XW-1), with any multiplier including -2^(YW-1), gives the exact product.
- R4: Done goes high exactly YW clock cycles after the clock edge that accepts start.
- R5: Busy rises only on the edge that accepts a start and stays high until the edge where done rises. Busy is low whenever done is high.
- R6: Done is high for exactly one cycle per accepted start.
- R7: A start request while busy is ignored. The product still belongs to the operands that were accepted, and the time to done does not change.
- R8: While idle and with no start request, product holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request to begin; taken only when idle |
| mcand | input | XW | Signed multiplicand, sampled with start |
| mplier | input | YW | Signed multiplier, sampled with start |
| busy | output | 1 | High while the steps are running |
| done | output | 1 | One-cycle pulse when the product is final |
| product | output | XW+YW | Signed product |

## Verification
Two configurations are swept exhaustively: a square 4x4 one and a lopsided 5x3 one. The lopsided one would expose any design that mixes up which width sets the step count or the placement of the fields. The most negative multiplicand is the key corner case. Without the guard bit, its negation wraps back to itself, so products that use it come out with the wrong sign. Some runs send a start request with scrambled operands in the middle of the run. A design that restarts or reloads its operands would then show a longer latency or a product of the wrong operands. Done and product are also checked on the cycle after done, which would catch a pulse that lasts too long or a product that drifts.

// File: rtl/booth_seq_pkg.sv
package booth_seq_pkg;

    // Control phase of the sequencer
    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_t;

    // Action selected by the recoded bit pair (low bit of the multiplier and the bit below it)
    typedef enum logic [1:0] {
        OP_KEEP = 2'b00,
        OP_ADD  = 2'b01,
        OP_SUB  = 2'b10
    } step_op_t;

    // The pair "01" ends a run of ones: add. The pair "10" starts one: subtract.
    function automatic step_op_t recode(input logic [1:0] pair);
        step_op_t op;
        case (pair)
            2'b01:   op = OP_ADD;
            2'b10:   op = OP_SUB;
            default: op = OP_KEEP;
        endcase
        return op;
    endfunction

    // Working register width: product bits, one guard bit, one trailing bit
    function automatic int work_width(input int xw, input int yw);
        return xw + yw + 2;
    endfunction

endpackage

// File: rtl/booth_operand_prep.sv
module booth_operand_prep
    import booth_seq_pkg::*;
#(
    parameter int XW = 8,
    parameter int YW = 8
) (
    input  logic [XW-1:0]                   mcand,
    input  logic [YW-1:0]                   mplier,
    output logic [work_width(XW, YW)-1:0]   add_word,
    output logic [work_width(XW, YW)-1:0]   sub_word,
    output logic [work_width(XW, YW)-1:0]   p_init
);
    localparam int LOW_Z = YW + 1;

    logic [XW:0] m_ext;
    logic [XW:0] m_neg;

    // With one extra sign bit, negating -2^(XW-1) cannot wrap
    always_comb begin
        m_ext = {mcand[XW-1], mcand};
        m_neg = (~m_ext) + 1'b1;
    end

    assign add_word = {m_ext, {LOW_Z{1'b0}}};
    assign sub_word = {m_neg, {LOW_Z{1'b0}}};
    assign p_init   = {{(XW + 1){1'b0}}, mplier, 1'b0};

endmodule

// File: rtl/booth_step.sv
module booth_step
    import booth_seq_pkg::*;
#(
    parameter int W = 18
) (
    input  logic [W-1:0] p_cur,
    input  logic [W-1:0] add_word,
    input  logic [W-1:0] sub_word,
    output logic [W-1:0] p_next
);
    step_op_t     op;
    logic [W-1:0] sum;

    always_comb begin
        op = recode(p_cur[1:0]);
        case (op)
            OP_ADD:  sum = p_cur + add_word;
            OP_SUB:  sum = p_cur + sub_word;
            default: sum = p_cur;
        endcase
        // Arithmetic shift right by one; carry out of the top is dropped
        p_next = {sum[W-1], sum[W-1:1]};
    end

endmodule

// File: rtl/booth_ctrl.sv
module booth_ctrl
    import booth_seq_pkg::*;
#(
    parameter int YW = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic load,
    output logic step_en,
    output logic busy,
    output logic done
);
    localparam int CW = $clog2(YW + 1);
    localparam logic [CW-1:0] LAST = CW'(YW - 1);

    phase_t        phase_q;
    logic [CW-1:0] cnt_q;
    logic          done_q;

    assign load    = (phase_q == PH_IDLE) && start;
    assign step_en = (phase_q == PH_RUN);
    assign busy    = (phase_q == PH_RUN);
    assign done    = done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (phase_q)
                PH_IDLE: begin
                    if (start) begin
                        phase_q <= PH_RUN;
                        cnt_q   <= '0;
                    end
                end
                PH_RUN: begin
                    if (cnt_q == LAST) begin
                        phase_q <= PH_IDLE;
                        done_q  <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/booth_seq_mult.sv
module booth_seq_mult
    import booth_seq_pkg::*;
#(
    parameter int XW = 8,
    parameter int YW = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [XW-1:0]    mcand,
    input  logic [YW-1:0]    mplier,
    output logic             busy,
    output logic             done,
    output logic [XW+YW-1:0] product
);
    localparam int W = work_width(XW, YW);

    logic         load;
    logic         step_en;
    logic [W-1:0] add_d, sub_d, init_d;
    logic [W-1:0] a_q, s_q, p_q;
    logic [W-1:0] p_nx;

    booth_operand_prep #(.XW(XW), .YW(YW)) u_prep (
        .mcand    (mcand),
        .mplier   (mplier),
        .add_word (add_d),
        .sub_word (sub_d),
        .p_init   (init_d)
    );

    booth_step #(.W(W)) u_step (
        .p_cur    (p_q),
        .add_word (a_q),
        .sub_word (s_q),
        .p_next   (p_nx)
    );

    booth_ctrl #(.YW(YW)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .load    (load),
        .step_en (step_en),
        .busy    (busy),
        .done    (done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q <= '0;
            s_q <= '0;
            p_q <= '0;
        end else if (load) begin
            a_q <= add_d;
            s_q <= sub_d;
            p_q <= init_d;
        end else if (step_en) begin
            p_q <= p_nx;
        end
    end

    // Drop the trailing bit; the guard bit above the product is only a sign copy
    assign product = p_q[XW+YW:1];

endmodule

// File: rtl/booth_seq_mult_chk.sv
module booth_seq_mult_chk #(
    parameter int XW = 8,
    parameter int YW = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic [XW+YW-1:0] product
);
    localparam int RW = $clog2(YW + 2);

    logic [RW-1:0] run_len;

    always_ff @(posedge clk) begin
        if (rst || !busy) run_len <= '0;
        else              run_len <= run_len + 1'b1;
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!busy && !done && product == '0));

    // R4
    done_latency_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (run_len == RW'(YW)));

    // R4
    run_bound_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> (run_len < RW'(YW)));

    // R5
    busy_entry_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));

    // R5
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R6
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R7
    busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && start && run_len != RW'(YW - 1)) |=> busy);

    // R8
    product_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> $stable(product));

endmodule

bind booth_seq_mult booth_seq_mult_chk #(.XW(XW), .YW(YW)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .product (product)
);

// File: tb/booth_sweep.sv
`timescale 1ns/1ps
module booth_sweep #(
    parameter int XW = 4,
    parameter int YW = 4
) (
    input  logic clk,
    input  logic rst,
    output logic finished,
    output int   n_run,
    output int   n_fail
);
    logic             start;
    logic [XW-1:0]    mcand;
    logic [YW-1:0]    mplier;
    logic             busy;
    logic             done;
    logic [XW+YW-1:0] product;

    booth_seq_mult #(.XW(XW), .YW(YW)) u0 (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .mcand   (mcand),
        .mplier  (mplier),
        .busy    (busy),
        .done    (done),
        .product (product)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s (XW=%0d YW=%0d) actual=%0d expected=%0d", req, XW, YW, act, exp);
        end
    endtask

    initial begin
        finished = 1'b0;
        n_run    = 0;
        n_fail   = 0;
        start    = 1'b0;
        mcand    = '0;
        mplier   = '0;
        @(negedge clk);
        while (rst) @(negedge clk);
        // R1: idle state right after reset
        check(busy == 1'b0, "R1 busy", longint'(busy), 0);
        check(done == 1'b0, "R1 done", longint'(done), 0);
        check(product == '0, "R1 product", longint'(product), 0);

        for (int mi = 0; mi < (1 << XW); mi++) begin
            for (int ri = 0; ri < (1 << YW); ri++) begin
                longint ms, rs, expv, got;
                int lat;
                bit intrude, busy_ok;
                logic [XW+YW-1:0] held;
                string req;
                ms = (mi >= (1 << (XW - 1))) ? longint'(mi - (1 << XW)) : longint'(mi);
                rs = (ri >= (1 << (YW - 1))) ? longint'(ri - (1 << YW)) : longint'(ri);
                expv = ms * rs;
                req = (mi == (1 << (XW - 1))) ? "R3 min mcand" : "R2 product";
                intrude = ((mi + ri) % 5) == 0;

                mcand  = XW'(mi);
                mplier = YW'(ri);
                start  = 1'b1;
                @(negedge clk);
                start = 1'b0;
                // R5: busy rises on the accepting edge
                check(busy == 1'b1, "R5 busy after start", longint'(busy), 1);
                lat = 0;
                busy_ok = 1'b1;
                do begin
                    if (intrude && lat == 0) begin
                        // R7: request with scrambled operands while busy
                        start  = 1'b1;
                        mcand  = ~XW'(mi);
                        mplier = ~YW'(ri);
                    end else begin
                        start = 1'b0;
                    end
                    @(negedge clk);
                    lat++;
                    if (!done && !busy) busy_ok = 1'b0;
                end while (!done && lat < 4 * YW + 8);
                start = 1'b0;

                got = longint'($signed(product));
                // R4: latency from the accepting edge
                check(lat == YW, intrude ? "R7 latency with start while busy" : "R4 latency",
                      longint'(lat), longint'(YW));
                check(busy_ok, "R5 busy held through run", 0, 1);
                check(busy == 1'b0, "R5 busy low with done", longint'(busy), 0);
                check(got == expv, intrude ? "R7 product with start while busy" : req, got, expv);
                held = product;
                @(negedge clk);
                // R6: done is one cycle wide
                check(done == 1'b0, "R6 done pulse width", longint'(done), 0);
                // R8: product holds while idle
                check(product == held, "R8 product hold", longint'(product), longint'(held));
            end
        end
        finished = 1'b1;
    end

endmodule

// File: tb/sim_booth_seq_mult.sv
`timescale 1ns/1ps
module sim_booth_seq_mult;
    logic clk = 1'b0;
    logic rst = 1'b1;

    logic f0, f1;
    int   r0, r1, e0, e1;

    always #2.5 clk = ~clk;

    booth_sweep #(.XW(4), .YW(4)) h0 (
        .clk (clk), .rst (rst), .finished (f0), .n_run (r0), .n_fail (e0)
    );

    booth_sweep #(.XW(5), .YW(3)) h1 (
        .clk (clk), .rst (rst), .finished (f1), .n_run (r1), .n_fail (e1)
    );

    initial begin
        int cyc;
        int wd_fail;
        wd_fail = 0;
        rst = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        cyc = 0;
        while (!(f0 === 1'b1 && f1 === 1'b1) && cyc < 190000) begin
            @(posedge clk);
            cyc++;
        end
        if (!(f0 === 1'b1 && f1 === 1'b1)) begin
            wd_fail = 1;
            $display("FAIL watchdog: actual=%0d cycles expected=sweeps finished", cyc);
        end
        $display("  [TB] %0d tests run, %0d failed", r0 + r1 + wd_fail, e0 + e1 + wd_fail);
        $finish;
    end

endmodule